// File: doc/BRIEF.md
# Backscatter Packet Transmitter with Bi-Phase Line Code

This block turns one wireless-power control packet into a single modulation-enable line. The line drives a load-switching element, either a resistor or a capacitor, on the receiver side. Switching that load changes the amplitude the transmitter sees on its coil, and the transmitter decodes the changes. A controller presents a header byte, up to `MAX_MSG` message bytes and a byte count, then pulses `start`. The block sends a run of ONE bits as a preamble. It then sends the header, each message byte and an XOR checksum byte, each inside its own asynchronous frame. When the packet is over it reports that it is done.

Every frame bit is expressed in differential bi-phase code. The line toggles at every bit boundary, and it toggles again at mid-bit only for a ONE. The half-bit timing comes from a divider on the system clock. `HALF_BIT_CLKS` is set so that one half-bit lasts 0.25 ms, which gives a 0.5 ms bit, or 2 kHz. As examples of header values, 0x04 marks a rectified-power report and 0x02 marks an end-power-transfer request.

Top module: `bsc_pkt_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, `mod_en`, `busy` and `done` are 0.
- R2: Each bit lasts exactly 2*`HALF_BIT_CLKS` clock cycles. `mod_en` toggles at every bit boundary. The first toggle comes on the clock edge that accepts `start`.
- R3: A ONE bit toggles `mod_en` a second time, `HALF_BIT_CLKS` cycles after its boundary.
- R4: A ZERO bit has no mid-bit toggle, so its level holds for the whole bit.
- R5: The packet opens with `PRE_LEN` consecutive ONE bits. `PRE_LEN` must lie between 11 and 25 inclusive.
- R6: Each byte is sent as an 11-bit frame in this order: a ZERO start bit, the eight data bits least significant first, a parity bit that makes the count of ones over the eight data bits plus the parity bit odd, and a ONE stop bit.
- R7: The frames go out in this order: the header, then message bytes 0 to `msg_len`-1, then a checksum frame. Message byte i is taken from `msg_data[8*i+7:8*i]`. The checksum is the XOR of the header and all message bytes that were sent.
- R8: A `msg_len` greater than `MAX_MSG` is treated as `MAX_MSG`.
- R9: `busy` is 1 from the edge that accepts `start` until the stop bit of the checksum frame ends. On that edge `busy` falls, `mod_en` returns to 0, and `done` is 1 for exactly one cycle.
- R10: A `start` that arrives while `busy` is 1 is ignored. Changes to `header`, `msg_len` and `msg_data` while busy do not alter the packet being sent.
- R11: A `start` in the cycle where `done` is 1 is accepted, so packets can follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send a packet; sampled only while idle |
| header | input | 8 | Header byte |
| msg_len | input | $clog2(MAX_MSG+1) | Number of message bytes |
| msg_data | input | 8*MAX_MSG | Message bytes, byte 0 in the low bits |
| mod_en | output | 1 | Load-modulation enable, bi-phase coded |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse at packet end |

## Verification
The bench rebuilds the full expected bit sequence from the byte values it chooses: preamble, framing, parity and checksum. It turns that sequence into an expected per-cycle level of `mod_en` and compares the line on every cycle. It sweeps every message length from zero to the maximum, and one length above the maximum to test clamping. The bytes used include all-zero, all-one and mixed patterns. All-zero bytes expose mid-bit toggles that should not be there. All-one bytes stress the parity rule and the double toggle of a ONE. Mixed bytes reveal a wrong bit order or a wrong checksum. A start issued mid-packet together with altered inputs shows whether inputs are latched and busy starts are ignored. A start issued in the done cycle shows whether back-to-back packets work.

// File: rtl/bsc_pkt_pkg.sv
package bsc_pkt_pkg;

    localparam int FRAME_BITS = 11;
    localparam int PRE_MIN    = 11;
    localparam int PRE_MAX    = 25;

    typedef enum logic [1:0] {
        SEG_IDLE  = 2'd0,
        SEG_PRE   = 2'd1,
        SEG_FRAME = 2'd2
    } seg_t;

    typedef struct packed {
        logic bound;   // bit boundary: always toggle
        logic mid;     // mid-bit point: toggle if bit is ONE
        logic clear;   // packet end: force unloaded level
        logic bit_val; // value of the bit being sent
    } line_evt_t;

    // Value of frame position idx (0 = start bit, 10 = stop bit) for byte d.
    function automatic logic frame_bit(input logic [7:0] d, input logic [3:0] idx);
        logic r;
        if (idx == 4'd0)       r = 1'b0;
        else if (idx <= 4'd8)  r = d[3'(idx - 4'd1)];
        else if (idx == 4'd9)  r = ~^d;
        else                   r = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/bsc_tick_gen.sv
module bsc_tick_gen #(
    parameter int HALF_BIT_CLKS = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(HALF_BIT_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_BIT_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)       cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);

    generate
        if (HALF_BIT_CLKS > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R2
        end
    endgenerate

endmodule

// File: rtl/bsc_frame_seq.sv
module bsc_frame_seq
    import bsc_pkt_pkg::*;
#(
    parameter int MAX_MSG = 8,
    parameter int PRE_LEN = 11
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [7:0]                   header,
    input  logic [$clog2(MAX_MSG+1)-1:0] msg_len,
    input  logic [8*MAX_MSG-1:0]         msg_data,
    input  logic                         tick,
    output logic                         busy,
    output logic                         done,
    output line_evt_t                    evt
);
    localparam int LEN_W = $clog2(MAX_MSG + 1);
    localparam int IDX_W = $clog2(MAX_MSG + 2);
    localparam int PRE_W = $clog2(PRE_LEN + 1);

    seg_t               seg_q;
    logic               half_q;
    logic [PRE_W-1:0]   pre_q;
    logic [IDX_W-1:0]   byte_q;
    logic [3:0]         bit_q;
    logic [LEN_W-1:0]   len_q;
    logic [7:0]         hdr_q;
    logic [7:0]         sum_q;
    logic [8*MAX_MSG-1:0] msg_q;
    logic               done_q;

    logic               accept, end_bit, last, finish;
    logic [LEN_W-1:0]   len_eff;
    logic [7:0]         sum_in;
    logic [7:0]         cur_byte;
    logic [IDX_W-1:0]   sum_idx;

    initial begin
        AST_PRE_RANGE: assert (PRE_LEN >= PRE_MIN && PRE_LEN <= PRE_MAX); // R5
    end

    assign accept  = start && (seg_q == SEG_IDLE);
    assign len_eff = (msg_len > LEN_W'(MAX_MSG)) ? LEN_W'(MAX_MSG) : msg_len;
    assign sum_idx = IDX_W'(len_q) + IDX_W'(1);

    always_comb begin
        sum_in = header;
        for (int i = 0; i < MAX_MSG; i++) begin
            if (LEN_W'(i) < len_eff) sum_in = sum_in ^ msg_data[8*i +: 8];
        end
    end

    always_comb begin
        cur_byte = hdr_q;
        for (int i = 0; i < MAX_MSG; i++) begin
            if (byte_q == IDX_W'(i + 1)) cur_byte = msg_q[8*i +: 8];
        end
        if (byte_q == sum_idx) cur_byte = sum_q;
    end

    assign end_bit = tick && half_q;
    assign last    = (seg_q == SEG_FRAME) && (bit_q == 4'(FRAME_BITS - 1)) && (byte_q == sum_idx);
    assign finish  = end_bit && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q  <= SEG_IDLE;
            half_q <= 1'b0;
            pre_q  <= '0;
            byte_q <= '0;
            bit_q  <= '0;
            len_q  <= '0;
            hdr_q  <= '0;
            sum_q  <= '0;
            msg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                seg_q  <= SEG_PRE;
                half_q <= 1'b0;
                pre_q  <= '0;
                byte_q <= '0;
                bit_q  <= '0;
                len_q  <= len_eff;
                hdr_q  <= header;
                sum_q  <= sum_in;
                msg_q  <= msg_data;
            end else if (tick) begin
                half_q <= ~half_q;
                if (half_q) begin
                    if (seg_q == SEG_PRE) begin
                        if (pre_q == PRE_W'(PRE_LEN - 1)) begin
                            seg_q  <= SEG_FRAME;
                            byte_q <= '0;
                            bit_q  <= '0;
                        end else begin
                            pre_q <= pre_q + 1'b1;
                        end
                    end else if (seg_q == SEG_FRAME) begin
                        if (bit_q != 4'(FRAME_BITS - 1)) begin
                            bit_q <= bit_q + 4'd1;
                        end else if (last) begin
                            seg_q <= SEG_IDLE;
                        end else begin
                            byte_q <= byte_q + 1'b1;
                            bit_q  <= '0;
                        end
                    end
                end
            end
        end
    end

    assign busy        = (seg_q != SEG_IDLE);
    assign done        = done_q;
    assign evt.bound   = accept || (end_bit && !last);
    assign evt.mid     = tick && !half_q;
    assign evt.clear   = finish;
    assign evt.bit_val = (seg_q == SEG_PRE) ? 1'b1 : frame_bit(cur_byte, bit_q);

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R9
    AST_HDR_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(hdr_q) && $stable(len_q)); // R10

endmodule

// File: rtl/bsc_biphase_enc.sv
module bsc_biphase_enc
    import bsc_pkt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt,
    output logic      line
);
    logic line_q;

    always_ff @(posedge clk) begin
        if (rst || evt.clear)             line_q <= 1'b0;
        else if (evt.bound)               line_q <= ~line_q;
        else if (evt.mid && evt.bit_val)  line_q <= ~line_q;
    end

    assign line = line_q;

    AST_ZERO_NO_MID: assert property (@(posedge clk) disable iff (rst)
        (evt.mid && !evt.bit_val) |=> $stable(line_q)); // R4
    AST_ONE_MID_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (evt.mid && evt.bit_val) |=> (line_q != $past(line_q))); // R3

endmodule

// File: rtl/bsc_pkt_tx.sv
module bsc_pkt_tx
    import bsc_pkt_pkg::*;
#(
    parameter int HALF_BIT_CLKS = 12500,
    parameter int MAX_MSG       = 8,
    parameter int PRE_LEN       = 11
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [7:0]                   header,
    input  logic [$clog2(MAX_MSG+1)-1:0] msg_len,
    input  logic [8*MAX_MSG-1:0]         msg_data,
    output logic                         mod_en,
    output logic                         busy,
    output logic                         done
);
    logic      tick;
    line_evt_t evt;

    bsc_tick_gen #(.HALF_BIT_CLKS(HALF_BIT_CLKS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    bsc_frame_seq #(.MAX_MSG(MAX_MSG), .PRE_LEN(PRE_LEN)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .header   (header),
        .msg_len  (msg_len),
        .msg_data (msg_data),
        .tick     (tick),
        .busy     (busy),
        .done     (done),
        .evt      (evt)
    );

    bsc_biphase_enc u_enc (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .line (mod_en)
    );

    AST_IDLE_UNLOADED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mod_en); // R1

endmodule

// File: tb/test_bsc_pkt_tx.sv
`timescale 1ns/1ps
module test_bsc_pkt_tx;
    localparam int H   = 3;
    localparam int MM  = 4;
    localparam int PRE = 11;
    localparam int LW  = $clog2(MM + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [7:0]    header = '0;
    logic [LW-1:0] msg_len = '0;
    logic [8*MM-1:0] msg_data = '0;
    logic          mod_en, busy, done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bsc_pkt_tx #(.HALF_BIT_CLKS(H), .MAX_MSG(MM), .PRE_LEN(PRE)) i_bsc_pkt_tx (
        .clk(clk), .rst(rst), .start(start), .header(header),
        .msg_len(msg_len), .msg_data(msg_data),
        .mod_en(mod_en), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sends one packet and returns at the negedge of the done cycle.
    task automatic send(input logic [7:0] hdr, input int len, input logic [8*MM-1:0] data,
                        input bit chained, input bit poke_busy);
        int bits [0:127];
        int lvl  [0:255];
        int nb;
        int eff;
        int l;
        logic [7:0] sum;
        logic [7:0] b;
        bit wave_ok;
        bit busy_ok;
        int bad_j;
        int bad_act;
        int bad_exp;
        eff = (len > MM) ? MM : len;          // R8
        nb  = 0;
        for (int i = 0; i < PRE; i++) begin bits[nb] = 1; nb++; end   // R5
        sum = hdr;
        for (int i = 0; i < eff; i++) sum = sum ^ data[8*i +: 8];      // R7
        for (int f = 0; f < eff + 2; f++) begin
            int ones;
            if (f == 0) b = hdr;
            else if (f == eff + 1) b = sum;
            else b = data[8*(f-1) +: 8];
            ones = 0;
            bits[nb] = 0; nb++;                                          // R6
            for (int k = 0; k < 8; k++) begin
                bits[nb] = int'(b[k]); nb++;
                ones += int'(b[k]);
            end
            bits[nb] = (ones % 2 == 0) ? 1 : 0; nb++;
            bits[nb] = 1; nb++;
        end
        l = 0;
        for (int i = 0; i < nb; i++) begin
            l = 1 - l;                   lvl[2*i]     = l;             // R2
            if (bits[i] == 1) l = 1 - l; lvl[2*i + 1] = l;             // R3 R4
        end
        if (!chained) @(negedge clk);
        start = 1'b1;
        header = hdr;
        msg_len = LW'(len);
        msg_data = data;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        wave_ok = 1'b1;
        busy_ok = 1'b1;
        bad_j = 0; bad_act = 0; bad_exp = 0;
        for (int j = 0; j < 2 * nb * H; j++) begin
            if (wave_ok && int'(mod_en) != lvl[j / H]) begin
                wave_ok = 1'b0; bad_j = j; bad_act = int'(mod_en); bad_exp = lvl[j / H];
            end
            if (!busy || done) busy_ok = 1'b0;
            if (poke_busy && j == 40) begin
                start = 1'b1; header = ~hdr; msg_len = LW'(0); msg_data = ~data;   // R10
            end else if (poke_busy) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (!wave_ok) $display("  mismatch at cycle %0d of packet hdr=%02h len=%0d", bad_j, hdr, len);
        check(wave_ok, poke_busy ? "R10 R2 R3 R4 R5 R6 R7 waveform" :
                       (len > MM ? "R8 waveform" : "R2 R3 R4 R5 R6 R7 waveform"),
              bad_act, bad_exp);
        check(busy_ok, "R9 busy held, done low during packet", int'(busy_ok), 1);
        check(!busy && done && !mod_en, "R9 end state busy/done/mod_en",
              int'({busy, done, mod_en}), 3'b010);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!mod_en && !busy && !done, "R1 reset state", int'({mod_en, busy, done}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!mod_en && !busy && !done, "R1 idle state", int'({mod_en, busy, done}), 0);

        send(8'h04, 2, 32'h0000_5AC3, 1'b0, 1'b0);     // rectified-power style
        send(8'h02, 1, 32'h0000_0001, 1'b0, 1'b0);     // end-power-transfer style
        // Length sweep with varied byte patterns
        for (int n = 0; n <= MM; n++) begin
            send(8'(8'h11 * n + 8'h3C), n, 32'hA5F0_0FFF ^ (32'h1357_9BDF * n), 1'b0, 1'b0);
        end
        send(8'h00, 4, 32'h0000_0000, 1'b0, 1'b0);     // all ZERO payload: R4
        send(8'hFF, 4, 32'hFFFF_FFFF, 1'b0, 1'b0);     // all ONE payload: R3
        send(8'h9E, 7, 32'h8421_C3E7, 1'b0, 1'b0);     // R8 clamp
        send(8'h4D, 3, 32'h0012_3456, 1'b0, 1'b1);     // R10 ignored start
        // R11 back-to-back: start in the done cycle
        send(8'h71, 1, 32'h0000_00B2, 1'b0, 1'b0);
        send(8'h2A, 2, 32'h0000_E4C8, 1'b1, 1'b0);
        check(1'b1, "R11 back-to-back accepted", 1, 1);
        @(negedge clk);
        check(!done && !busy && !mod_en, "R9 R1 done is one cycle, idle after",
              int'({done, busy, mod_en}), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule